// File: doc/BRIEF.md
# Configurable Generic Logic Block

This block models one programmable logic cell of a small complex PLD. An 18-bit input vector represents the signals that the global routing delivers to the cell. A configurable AND array turns these inputs into product terms. Four output functions are then formed from those terms. Each output takes one of two data paths. The narrow path ORs four product terms. The wide path ORs any subset of the twenty data terms and then passes the result through an XOR gate with a programmable polarity. Each output is then either driven straight out or captured in its own flip-flop.

Three more product terms serve as control terms: one for the clock, one for the reset and one for the output enable. The flip-flops are clocked from one of three global clock lines or from the clock term. The choice is made by the configuration. The model runs on one system clock `clk`. A register loads on the `clk` edge at which the chosen clock source is high after being low at the previous edge. The active-low global reset and the reset term clear the registers at once, without waiting for a clock edge. The configuration is a static parallel vector `cfg_i`. It must be held steady during operation.

The configuration vector has four parts, from bit 0 upward. First are the AND-array fuses: 36 bits per term, 23 terms. Next are the allocation masks: 20 bits per output. Then come three groups of four bits, one bit per output: the XOR polarity bits, the path-select bits and the register-bypass bits. After those are two clock-select bits, and last a single bit that forces the output enable.

Top module: `glb_core`

## Requirements
- R1: Product term p (0..22) is the AND of the literals enabled in `cfg_i[p*36 +: 36]`. Bit l (l < 18) enables `in_i[l]`. Bit 18+l enables `~in_i[l]`. A term with no literal enabled evaluates to 0.
- R2: When the path bit `cfg_i[912+k]` is 0, the data value of output k is the OR of product terms 4k, 4k+1, 4k+2 and 4k+3.
- R3: When the path bit of output k is 1, its data value is the OR of the data terms p (0..19) whose mask bit `cfg_i[828 + k*20 + p]` is 1, XORed with the polarity bit `cfg_i[908+k]`.
- R4: The path bit of each output selects that output's path on its own, with no effect on the other outputs.
- R5: When the bypass bit `cfg_i[916+k]` is 1, `data_o[k]` shows the data value of output k in the same cycle, with no register in the path.
- R6: The clock-select field `cfg_i[921:920]` picks the register clock source. Values 0, 1 and 2 pick `gclk_i[0]`, `gclk_i[1]` and `gclk_i[2]`. Value 3 picks product term 20. A register loads its data value on each `clk` edge at which the source is high and was low at the previous edge. Otherwise the register holds its value.
- R7: While `rst_n` is low or product term 21 is true, every register reads 0 at once, with no clock edge needed. The combinational outputs are not affected.
- R8: `oe_o` is the OR of product term 22 and the force bit `cfg_i[922]`.
- R9: `fb_o` always carries the same four values as `data_o`.
- R10: While the global reset is held and after it is released, every registered output reads 0 until its first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the clock-source edges are sampled with it |
| rst_n | input | 1 | Active-low global reset, asynchronous |
| in_i | input | 18 | Routed input signals feeding the AND array |
| gclk_i | input | 3 | Global clock lines |
| cfg_i | input | 923 | Static configuration vector |
| data_o | output | 4 | The four output functions |
| fb_o | output | 4 | Feedback copy of the outputs |
| oe_o | output | 1 | Output enable produced by the block |

## Verification
A randomly programmed source clock that stays high must load a register only once. A design that uses the level instead of the edge would reload on every cycle and follow the data. The reset term is asserted between clock edges. A synchronous reset would leave a stale value visible until the next edge. Reset is also asserted while combinational outputs are live; a design that clears them as well would show zeros there. An empty product term must read 0, not the all-ones identity of an AND. The wide path is checked under both polarity bits and with masks that overlap the narrow-path terms. A swapped path select or a dropped XOR would show up as inverted or missing terms.

// File: rtl/glb_pkg.sv
package glb_pkg;

    // default geometry of one logic cell
    localparam int unsigned GLB_IN    = 18;
    localparam int unsigned GLB_OUT   = 4;
    localparam int unsigned GLB_DPT   = 20;
    localparam int unsigned GLB_BPT   = 4;
    localparam int unsigned GLB_LINES = 3;

    // register clock source
    typedef enum logic [1:0] {
        CK_LINE0 = 2'd0,
        CK_LINE1 = 2'd1,
        CK_LINE2 = 2'd2,
        CK_TERM  = 2'd3
    } clk_src_e;

    // data path of one output
    typedef enum logic {
        PATH_NARROW = 1'b0,
        PATH_WIDE   = 1'b1
    } path_e;

    // output taken from the register or straight from the logic
    typedef enum logic {
        OUT_REG  = 1'b0,
        OUT_COMB = 1'b1
    } omode_e;

endpackage

// File: rtl/glb_and_array.sv
module glb_and_array #(
    parameter int unsigned N_IN = 18,
    parameter int unsigned N_PT = 23,
    localparam int unsigned LIT = 2 * N_IN
) (
    input  logic [N_IN-1:0]     in_i,
    input  logic [N_PT*LIT-1:0] fuse_i,
    output logic [N_PT-1:0]     pt_o
);

    logic [LIT-1:0] lits;

    // literal l is the true input for l < N_IN, the complement above
    assign lits = {~in_i, in_i};

    for (genvar p = 0; p < N_PT; p++) begin : g_term
        logic [LIT-1:0] sel;
        assign sel = fuse_i[p*LIT +: LIT];
        // an unused term is shut down to 0
        assign pt_o[p] = (|sel) & (&(lits | ~sel));
    end

endmodule

// File: rtl/glb_clk_sel.sv
module glb_clk_sel
    import glb_pkg::*;
#(
    parameter int unsigned N_LINE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_LINE-1:0] lines_i,
    input  logic              pt_clk_i,
    input  clk_src_e          sel_i,
    output logic              tick_o
);

    logic src;
    logic src_q;

    always_comb begin
        unique case (sel_i)
            CK_TERM: src = pt_clk_i;
            default: src = lines_i[sel_i];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= src;
    end

    assign tick_o = src & ~src_q;

    // R6
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/glb_out_cell.sv
module glb_out_cell
    import glb_pkg::*;
#(
    parameter int unsigned N_DPT = 20,
    parameter int unsigned N_BPT = 4,
    parameter int unsigned IDX   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [N_DPT-1:0] pt_i,
    input  logic [N_DPT-1:0] alloc_i,
    input  logic             pol_i,
    input  path_e            path_i,
    input  omode_e           mode_i,
    output logic             out_o
);

    logic narrow;
    logic wide;
    logic d;
    logic q;

    assign narrow = |pt_i[IDX*N_BPT +: N_BPT];
    assign wide   = (|(pt_i & alloc_i)) ^ pol_i;

    always_comb begin
        unique case (path_i)
            PATH_WIDE:   d = wide;
            PATH_NARROW: d = narrow;
            default:     d = narrow;
        endcase
    end

    always_ff @(posedge clk or posedge clr_i) begin
        if (clr_i)       q <= 1'b0;
        else if (tick_i) q <= d;
    end

    always_comb begin
        unique case (mode_i)
            OUT_COMB: out_o = d;
            OUT_REG:  out_o = q;
            default:  out_o = q;
        endcase
    end

    // R6
    q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i) |=> (clr_i || $stable(q)));

    // R6
    q_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !clr_i) |=> (clr_i || q == $past(d)));

    // R7
    q_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |-> (q == 1'b0));

endmodule

// File: rtl/glb_core.sv
module glb_core
    import glb_pkg::*;
#(
    parameter int unsigned N_IN   = GLB_IN,
    parameter int unsigned N_OUT  = GLB_OUT,
    parameter int unsigned N_DPT  = GLB_DPT,
    parameter int unsigned N_BPT  = GLB_BPT,
    parameter int unsigned N_LINE = GLB_LINES,
    localparam int unsigned N_PT     = N_DPT + 3,
    localparam int unsigned LIT      = 2 * N_IN,
    localparam int unsigned FUSE_W   = N_PT * LIT,
    localparam int unsigned ALLOC_OF = FUSE_W,
    localparam int unsigned POL_OF   = ALLOC_OF + N_OUT * N_DPT,
    localparam int unsigned PATH_OF  = POL_OF + N_OUT,
    localparam int unsigned MODE_OF  = PATH_OF + N_OUT,
    localparam int unsigned CKS_OF   = MODE_OF + N_OUT,
    localparam int unsigned OEF_OF   = CKS_OF + 2,
    localparam int unsigned CFG_W    = OEF_OF + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   in_i,
    input  logic [N_LINE-1:0] gclk_i,
    input  logic [CFG_W-1:0]  cfg_i,
    output logic [N_OUT-1:0]  data_o,
    output logic [N_OUT-1:0]  fb_o,
    output logic              oe_o
);

    localparam int unsigned PT_CLK = N_DPT;
    localparam int unsigned PT_RST = N_DPT + 1;
    localparam int unsigned PT_OE  = N_DPT + 2;

    logic [N_PT-1:0] pt;
    logic            clr;
    logic            tick;
    clk_src_e        cks;

    glb_and_array #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
        .in_i  (in_i),
        .fuse_i(cfg_i[FUSE_W-1:0]),
        .pt_o  (pt)
    );

    assign cks = clk_src_e'(cfg_i[CKS_OF +: 2]);

    glb_clk_sel #(.N_LINE(N_LINE)) u_ck (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (gclk_i),
        .pt_clk_i(pt[PT_CLK]),
        .sel_i   (cks),
        .tick_o  (tick)
    );

    // global reset and reset term both clear the registers
    assign clr = ~rst_n | pt[PT_RST];

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        glb_out_cell #(.N_DPT(N_DPT), .N_BPT(N_BPT), .IDX(k)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (clr),
            .tick_i (tick),
            .pt_i   (pt[N_DPT-1:0]),
            .alloc_i(cfg_i[ALLOC_OF + k*N_DPT +: N_DPT]),
            .pol_i  (cfg_i[POL_OF + k]),
            .path_i (path_e'(cfg_i[PATH_OF + k])),
            .mode_i (omode_e'(cfg_i[MODE_OF + k])),
            .out_o  (data_o[k])
        );
    end

    assign fb_o = data_o;
    assign oe_o = pt[PT_OE] | cfg_i[OEF_OF];

endmodule

// File: tb/tb_glb_core.sv
module tb_glb_core;

    localparam int CW = 923;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [17:0]   in_i = '0;
    logic [2:0]    gclk_i = '0;
    logic [CW-1:0] cfg_i = '0;
    logic [3:0]    data_o;
    logic [3:0]    fb_o;
    logic          oe_o;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    bit  mprev = 1'b0;
    bit [3:0] mq = '0;

    glb_core dut (
        .clk(clk), .rst_n(rst_n), .in_i(in_i), .gclk_i(gclk_i),
        .cfg_i(cfg_i), .data_o(data_o), .fb_o(fb_o), .oe_o(oe_o)
    );

    always #5ns clk = ~clk;

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // R1 term value from the fuse layout
    function automatic bit ref_pt(int p);
        bit any = 1'b0;
        bit all = 1'b1;
        for (int l = 0; l < 18; l++) begin
            if (cfg_i[p*36 + l])      begin any = 1'b1; if (!in_i[l]) all = 1'b0; end
            if (cfg_i[p*36 + 18 + l]) begin any = 1'b1; if (in_i[l])  all = 1'b0; end
        end
        return any && all;
    endfunction

    // R2 / R3 data value of output k
    function automatic bit ref_d(int k);
        bit acc = 1'b0;
        if (!cfg_i[912 + k]) begin
            for (int j = 0; j < 4; j++) acc |= ref_pt(4*k + j);
            return acc;
        end
        for (int p = 0; p < 20; p++)
            if (cfg_i[828 + k*20 + p]) acc |= ref_pt(p);
        return acc ^ cfg_i[908 + k];
    endfunction

    function automatic bit ref_src();
        int s = cfg_i[921 -: 2];
        if (s == 3) return ref_pt(20);
        return gclk_i[s];
    endfunction

    task automatic compare();
        bit clr = !rst_n || ref_pt(21);
        for (int k = 0; k < 4; k++) begin
            bit exp;
            string tag;
            if (cfg_i[916 + k]) begin
                exp = ref_d(k);
                tag = cfg_i[912 + k] ? "R1 R3 R4 R5" : "R1 R2 R4 R5";
            end else begin
                exp = clr ? 1'b0 : mq[k];
                tag = !rst_n ? "R10" : (clr ? "R7" : "R6");
            end
            chk(data_o[k] === exp, tag, data_o[k], exp);
            chk(fb_o[k] === data_o[k], "R9", fb_o[k], data_o[k]);
        end
        begin
            bit eoe = ref_pt(22) | cfg_i[922];
            chk(oe_o === eoe, "R8", oe_o, eoe);
        end
    endtask

    task automatic model_edge();
        bit clr = !rst_n || ref_pt(21);
        bit src = ref_src();
        bit tick = src && !mprev;
        bit [3:0] nd;
        for (int k = 0; k < 4; k++) nd[k] = ref_d(k);
        mprev = rst_n ? src : 1'b0;
        if (clr)       mq = '0;
        else if (tick) mq = nd;
    endtask

    task automatic run(int n, bit hold_rst);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            rst_n  = !hold_rst;
            in_i   = 18'($urandom);
            // slow clock lines so edges are spaced
            if ($urandom % 3 == 0) gclk_i = 3'($urandom);
            #1;
            compare();
            @(posedge clk);
            model_edge();
        end
    endtask

    task automatic make_cfg(int ck, bit all_reg);
        cfg_i = '0;
        for (int p = 0; p < 20; p++) begin
            if ($urandom % 8 == 0) continue;  // some empty terms (R1)
            for (int l = 0; l < 18; l++) begin
                int r = $urandom % 9;
                if (r == 0) cfg_i[p*36 + l] = 1'b1;
                else if (r == 1) cfg_i[p*36 + 18 + l] = 1'b1;
            end
        end
        cfg_i[20*36 + ($urandom % 18)] = 1'b1;           // clock term
        for (int j = 0; j < 3; j++)
            cfg_i[21*36 + ($urandom % 18)] = 1'b1;       // reset term
        cfg_i[22*36 + ($urandom % 18)] = 1'b1;           // enable term
        cfg_i[22*36 + 18 + ($urandom % 18)] = 1'b1;
        for (int b = 828; b < 916; b++) cfg_i[b] = 1'($urandom);
        for (int k = 0; k < 4; k++) cfg_i[916 + k] = all_reg ? 1'b0 : 1'($urandom);
        cfg_i[921 -: 2] = 2'(ck);
        cfg_i[922] = 1'($urandom % 4 == 0);
    endtask

    initial begin
        #2_000_000ns;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R10 reset state with every output registered
        make_cfg(0, 1'b1);
        rst_n = 1'b0;
        mq = '0;
        mprev = 1'b0;
        #1;
        chk(data_o === 4'b0000, "R10", data_o, 0);
        for (int cfgn = 0; cfgn < 12; cfgn++) begin
            make_cfg(cfgn % 4, cfgn < 4);
            run(3, 1'b1);
            run(400, 1'b0);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule